// File: doc/BRIEF.md
# Two-Byte Software Reset Unlock

This block guards a software-triggered reset behind a fixed two-write unlock sequence. It observes a write-only register slot on a register bus. The first write to that slot must carry A5h. The very next write to the same slot must carry 5Ah. When both arrive in that order, the block emits a one-cycle reset pulse. Any other value written to the slot drops the attempt without notice. A write to any other register between the two writes has the same effect.

The bus side is plain control: a write strobe, an address-match flag, the write data byte and a marker for writes that land elsewhere. Register writes are always accepted in the cycle they are presented, so there is no back-pressure and no valid/ready handshake. Reading the slot returns zero. Reads produce no write strobe, so they never touch the unlock progress. Cycles with no write at all do not count as a break either.

Top module: `sw_reset_unlock`

## Requirements
- R1: After the asynchronous active-low reset, `rst_pulse` is low and the detector is idle, so a lone 5Ah write produces no pulse.
- R2: A write of A5h to the slot followed by a write of 5Ah as the next write produces `rst_pulse` high for the one cycle that follows the clock edge sampling the 5Ah write.
- R3: A first write of any value other than A5h does not arm the detector, so a 5Ah write after it produces no pulse.
- R4: Once armed, a write to the slot of any value other than 5Ah or A5h returns the detector to idle, so a following 5Ah produces no pulse.
- R5: Once armed, a write of A5h to the slot keeps the detector armed as a fresh first byte, so the sequence A5h, A5h, 5Ah pulses once.
- R6: A cycle with `other_wr` high returns the detector to idle. This holds even when a slot write is presented in the same cycle, and such a slot write is discarded.
- R7: `rd_data` is always zero. Reading the slot between the two writes does not stop the pulse.
- R8: The pulse lasts exactly one cycle and leaves the detector idle, so a further lone 5Ah write produces no pulse.
- R9: Cycles without `wr_en` are not writes, whatever `addr_hit` and `wr_data` carry, so they neither break nor advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr_hit | input | 1 | Write address selects the reset slot |
| wr_data | input | 8 | Write data byte |
| other_wr | input | 1 | A write to some other register happens this cycle |
| rd_data | output | 8 | Read value of the slot, constant zero |
| rst_pulse | output | 1 | One-cycle reset request |

## Verification
Wrong unlock state has only one place to show at the ports: the presence or absence of `rst_pulse` one cycle after a later 5Ah write. A stuck or leaked armed state therefore stays hidden until the next 5Ah write, and it shows in the cycle right after that write. For this reason every stimulus pattern here ends with a 5Ah write and a pulse sample. The bench sweeps all 256 first bytes and all 256 second bytes, and then runs the break, re-arm, read and idle-cycle patterns.

// File: rtl/sw_reset_unlock_pkg.sv
package sw_reset_unlock_pkg;
  typedef enum logic [0:0] {
    UL_IDLE  = 1'b0,
    UL_ARMED = 1'b1
  } unlock_state_t;

  localparam int unsigned KEY_IDX_FIRST  = 0;
  localparam int unsigned KEY_IDX_SECOND = 1;
  localparam int unsigned NUM_KEYS       = 2;
endpackage

// File: rtl/ul_key_match.sv
module ul_key_match #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_KEYS = 2,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEYS = '0
) (
  input  logic [DATA_W-1:0]   data,
  output logic [NUM_KEYS-1:0] hit
);
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign hit[k] = (data == KEYS[k*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/ul_sequencer.sv
module ul_sequencer
  import sw_reset_unlock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot_wr,
  input  logic brk,
  input  logic is_first,
  input  logic is_second,
  output logic armed,
  output logic fire
);
  unlock_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (brk) begin
      state_d = UL_IDLE;
    end else if (slot_wr) begin
      unique case (state_q)
        UL_IDLE:  state_d = is_first ? UL_ARMED : UL_IDLE;
        UL_ARMED: begin
          if (is_second) begin
            fire    = 1'b1;
            state_d = UL_IDLE;
          end else if (is_first) begin
            state_d = UL_ARMED;
          end else begin
            state_d = UL_IDLE;
          end
        end
        default:  state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/ul_pulse_reg.sv
module ul_pulse_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end
endmodule

// File: rtl/sw_reset_unlock.sv
module sw_reset_unlock
  import sw_reset_unlock_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              other_wr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_pulse
);
  localparam logic [NUM_KEYS*DATA_W-1:0] KEY_VEC = {KEY_SECOND, KEY_FIRST};

  logic [NUM_KEYS-1:0] key_hit;
  logic slot_wr;
  logic armed;
  logic fire;

  assign slot_wr = wr_en & addr_hit;
  assign rd_data = '0;

  ul_key_match #(
    .DATA_W   (DATA_W),
    .NUM_KEYS (NUM_KEYS),
    .KEYS     (KEY_VEC)
  ) u_match (
    .data (wr_data),
    .hit  (key_hit)
  );

  ul_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_wr   (slot_wr),
    .brk       (other_wr),
    .is_first  (key_hit[KEY_IDX_FIRST]),
    .is_second (key_hit[KEY_IDX_SECOND]),
    .armed     (armed),
    .fire      (fire)
  );

  ul_pulse_reg u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (rst_pulse)
  );
endmodule

// File: rtl/sw_reset_unlock_chk.sv
module sw_reset_unlock_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr_hit,
  input logic [DATA_W-1:0] wr_data,
  input logic              other_wr,
  input logic              armed,
  input logic              rst_pulse
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_en && addr_hit && !other_wr && wr_data == KEY_SECOND && armed)); // R2
  AST_FIRST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hit && !other_wr && wr_data == KEY_FIRST) |=> armed); // R5
  AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> (!armed && !rst_pulse)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !other_wr) |=> (armed == $past(armed) && !rst_pulse)); // R9
  AST_BAD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hit && wr_data != KEY_FIRST && wr_data != KEY_SECOND) |=> !armed); // R4
endmodule

bind sw_reset_unlock sw_reset_unlock_chk #(
  .DATA_W     (DATA_W),
  .KEY_FIRST  (KEY_FIRST),
  .KEY_SECOND (KEY_SECOND)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr_hit  (addr_hit),
  .wr_data   (wr_data),
  .other_wr  (other_wr),
  .armed     (armed),
  .rst_pulse (rst_pulse)
);

// File: tb/sw_reset_unlock_test.sv
module sw_reset_unlock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr_hit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       other_wr = 1'b0;
  logic [7:0] rd_data;
  logic       rst_pulse;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sw_reset_unlock uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hit(addr_hit),
    .wr_data(wr_data), .other_wr(other_wr), .rd_data(rd_data), .rst_pulse(rst_pulse)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle; afterwards rst_pulse reflects this cycle's write.
  task automatic cyc(input logic we, input logic hit, input logic [7:0] d, input logic oth);
    @(negedge clk);
    wr_en = we; addr_hit = hit; wr_data = d; other_wr = oth;
    @(negedge clk);
    wr_en = 1'b0; addr_hit = 1'b0; wr_data = 8'h00; other_wr = 1'b0;
  endtask

  task automatic slot(input logic [7:0] d);
    cyc(1'b1, 1'b1, d, 1'b0);
  endtask

  // Leaves the detector idle whatever it held.
  task automatic flush();
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", {7'd0, rst_pulse}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pulse after reset", {7'd0, rst_pulse}, 8'h00);
    slot(8'h5A);
    check("R1 lone second key", {7'd0, rst_pulse}, 8'h00);

    // R3 / R2: sweep every first byte, then the second key
    for (int b = 0; b < 256; b++) begin
      flush();
      slot(b[7:0]);
      check("R3 first byte no pulse", {7'd0, rst_pulse}, 8'h00);
      check("R7 read zero", rd_data, 8'h00);
      slot(8'h5A);
      check("R3 sweep first", {7'd0, rst_pulse}, {7'd0, b == 8'hA5});
    end

    // R2 / R4 / R5: sweep every second byte, then a closing second key
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = b[7:0];
      flush();
      slot(8'hA5);
      slot(bb);
      check("R2 sweep second", {7'd0, rst_pulse}, {7'd0, bb == 8'h5A});
      if (bb == 8'h5A) begin
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        check("R8 pulse one cycle", {7'd0, rst_pulse}, 8'h00);
      end
      slot(8'h5A);
      check("R4 R5 R8 closing key", {7'd0, rst_pulse}, {7'd0, bb == 8'hA5});
    end

    // R6: other write between keys
    flush(); slot(8'hA5); cyc(1'b1, 1'b0, 8'h33, 1'b1); slot(8'h5A);
    check("R6 other write breaks", {7'd0, rst_pulse}, 8'h00);
    // R6: other write together with the second key
    flush(); slot(8'hA5); cyc(1'b1, 1'b1, 8'h5A, 1'b1);
    check("R6 same cycle break", {7'd0, rst_pulse}, 8'h00);
    slot(8'h5A);
    check("R6 idle after break", {7'd0, rst_pulse}, 8'h00);

    // R7: a read cycle (no strobe) between keys
    flush(); slot(8'hA5); cyc(1'b0, 1'b1, 8'h00, 1'b0);
    check("R7 read zero armed", rd_data, 8'h00);
    slot(8'h5A);
    check("R7 read keeps sequence", {7'd0, rst_pulse}, 8'h00 | 8'h01);

    // R9: stray data without strobe is no write
    for (int g = 0; g < 4; g++) begin
      flush(); slot(8'hA5);
      for (int k = 0; k <= g; k++) cyc(1'b0, 1'b1, 8'h11 + k[7:0], 1'b0);
      check("R9 no strobe no pulse", {7'd0, rst_pulse}, 8'h00);
      slot(8'h5A);
      check("R9 gap keeps armed", {7'd0, rst_pulse}, 8'h01);
    end
    // R9: strobe without address is not a slot write
    flush(); cyc(1'b1, 1'b0, 8'hA5, 1'b0); slot(8'h5A);
    check("R9 unaddressed first", {7'd0, rst_pulse}, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule